// File: doc/BRIEF.md
# Iterative Integer Divide and Modulus Unit

This block is the multi-cycle divide engine of a 64-bit integer pipeline. The issue stage raises a start strobe with two raw register values, the low-order function field of the instruction and a destination register tag. The unit derives its own operation flags from that field: quotient or remainder, signed or unsigned, word or doubleword, normal or extended dividend, and whether a condition code is wanted. It then shapes the operands, divides magnitudes with a restoring shift-subtract loop that settles one quotient bit per clock, and corrects signs. It reports the finished value with a one-cycle done strobe, the tag, an overflow flag and an optional three-bit condition code.

Word forms take their operands from the low 32 bits. Extended forms treat the dividend as shifted left by the operand width. For doublewords this means a 128-bit dividend, which the loop handles by preloading the partial remainder with the dividend magnitude. A zero divisor, the most-negative-divided-by-minus-one case, and any extended quotient too wide for the result all give a zero result with the overflow flag set.

Top module: `int_div_unit`

## Requirements
- R1: The function field is decoded as follows. Bit 8 = 1 selects quotient and bit 8 = 0 selects remainder. Signedness is bit 6 for quotient forms and bit 10 for remainder forms. Bit 2 = 1 selects word (32-bit) mode. Bit 0 requests a condition code. Extended applies only when bit 8 = 1 and bit 7 = 0, so bit 7 has no effect on remainder forms. Bits 9 and 1 are 1 and bits 5:3 are 010 whenever start is accepted.
- R2: A start seen while the unit is idle is accepted, and busy_o is high from the next cycle. done_o is a single-cycle pulse exactly 66 cycles after the accepting edge (one setup cycle, 64 iteration cycles and one fixup cycle), and busy_o is low while done_o is high.
- R3: A start while busy_o is high has no effect on the result, the tag or the timing of the operation in progress.
- R4: Unsigned doubleword operation gives floor quotient and remainder of the 64-bit operands.
- R5: Signed operation truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R6: In word mode, both operands come from bits 31:0 of the inputs, sign-extended when signed and zero-extended otherwise. The result is extended from bit 31 in the same way.
- R7: An extended word dividend is the low word times 2^32. An extended doubleword dividend is the full operand times 2^64.
- R8: A zero divisor gives result 0 with ovf_o = 1, for quotient and remainder forms alike.
- R9: A quotient that does not fit the result width as a signed (or unsigned) value gives result 0 with ovf_o = 1. This covers the most negative value divided by -1 and wide extended quotients.
- R10: When bit 0 of the field was set, cc_o at done is {negative, positive, zero} of the 64-bit result as a signed value, with cc_o[2] = negative, cc_o[1] = positive and cc_o[0] = zero. Otherwise cc_o is 000.
- R11: tag_o at done equals the tag presented with the accepted start.
- R12: After reset, busy_o, done_o, result_o, ovf_o, cc_o and tag_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| func_i | input | 11 | Low function field of the instruction |
| dividend_i | input | 64 | First register operand |
| divisor_i | input | 64 | Second register operand |
| tag_i | input | 5 | Destination register tag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 64 | Quotient or remainder, held until next done |
| ovf_o | output | 1 | Overflow or divide-by-zero |
| cc_o | output | 3 | Condition code {negative, positive, zero} |
| tag_o | output | 5 | Tag of the finished operation |

## Verification
A corrupted loop counter or state register shows first as a done pulse that arrives early, late or twice, and as busy_o that disagrees with the expected window. A per-cycle comparison of busy_o and done_o catches this on the first wrong cycle. A wrong partial remainder, shift or sign flag only surfaces at the done cycle, as a result, overflow flag or condition code that differs from the reference. So the stimulus covers every mix of sign, width and extended form, and both sides of every overflow limit.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;

  typedef struct packed {
    logic is_rem;
    logic is_sgn;
    logic is_w32;
    logic is_ext;
    logic want_cc;
  } div_op_t;

  localparam int unsigned FUNC_W = 11;

  // positions the decode stage relies on
  localparam int unsigned FB_SGN_REM = 10;
  localparam int unsigned FB_QUOT    = 8;
  localparam int unsigned FB_NORMAL  = 7;
  localparam int unsigned FB_SGN_QUO = 6;
  localparam int unsigned FB_WORD    = 2;
  localparam int unsigned FB_CC      = 0;

endpackage

// File: rtl/div_decode.sv
module div_decode
  import div_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output div_op_t           op_o
);

  always_comb begin
    op_o.is_rem  = ~func_i[FB_QUOT];
    op_o.is_sgn  = func_i[FB_QUOT] ? func_i[FB_SGN_QUO] : func_i[FB_SGN_REM];
    op_o.is_w32  = func_i[FB_WORD];
    op_o.is_ext  = func_i[FB_QUOT] & ~func_i[FB_NORMAL];
    op_o.want_cc = func_i[FB_CC];
  end

endmodule

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/div_shape.sv
module div_shape
  import div_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  div_op_t      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_mag_o,
  output logic [W-1:0] lo_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o,
  output logic         pre_ovf_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] a_base, b_base, a_mag, b_mag;
  logic         a_neg, b_neg;

  always_comb begin
    if (op_i.is_w32) begin
      if (op_i.is_ext) begin
        a_base = {a_i[HALF-1:0], {HALF{1'b0}}};
      end else if (op_i.is_sgn) begin
        a_base = {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
      end else begin
        a_base = {{HALF{1'b0}}, a_i[HALF-1:0]};
      end
      if (op_i.is_sgn) begin
        b_base = {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
      end else begin
        b_base = {{HALF{1'b0}}, b_i[HALF-1:0]};
      end
    end else begin
      a_base = a_i;
      b_base = b_i;
    end

    a_neg = op_i.is_sgn & a_base[W-1];
    b_neg = op_i.is_sgn & b_base[W-1];
    a_mag = a_neg ? (~a_base + 1'b1) : a_base;
    b_mag = b_neg ? (~b_base + 1'b1) : b_base;

    // a doubleword extended dividend sits entirely in the upper half
    if (op_i.is_ext && !op_i.is_w32) begin
      hi_mag_o = a_mag;
      lo_mag_o = '0;
    end else begin
      hi_mag_o = '0;
      lo_mag_o = a_mag;
    end

    dvs_mag_o = b_mag;
    neg_quo_o = a_neg ^ b_neg;
    neg_rem_o = a_neg;
    // zero divisor, or upper dividend half already too large for a W-bit quotient
    pre_ovf_o = (b_mag == '0) | (hi_mag_o >= b_mag);
  end

endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         step_en,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] shq_q, shq_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   trial;
  logic         fits;

  always_comb begin
    trial = {rem_q, shq_q[W-1]};
    fits  = trial >= {1'b0, dvs_q};
    rem_d = rem_q;
    shq_d = shq_q;
    dvs_d = dvs_q;
    if (load_en) begin
      rem_d = hi_i;
      shq_d = lo_i;
      dvs_d = dvs_i;
    end else if (step_en) begin
      rem_d = fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
      shq_d = {shq_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      shq_q <= '0;
      dvs_q <= '0;
    end else if (load_en || step_en) begin
      rem_q <= rem_d;
      shq_q <= shq_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_o = shq_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && (rem_q < dvs_q)) |=> (rem_q < dvs_q)); // R4

endmodule

// File: rtl/div_fixup.sv
module div_fixup
  import div_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  div_op_t      op_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  input  logic         pre_ovf_i,
  output logic [W-1:0] result_o,
  output logic         ovf_o,
  output logic [2:0]   cc_o
);

  localparam int unsigned HALF = W / 2;

  logic         top_bit, low_nz, upper_nz, quo_ovf, flip;
  logic [W-1:0] mag, signed_val;

  always_comb begin
    if (op_i.is_w32) begin
      top_bit  = quo_i[HALF-1];
      low_nz   = |quo_i[HALF-2:0];
      upper_nz = |quo_i[W-1:HALF];
    end else begin
      top_bit  = quo_i[W-1];
      low_nz   = |quo_i[W-2:0];
      upper_nz = 1'b0;
    end
    // a negative quotient may reach exactly 2^(n-1); a positive one may not
    quo_ovf = ~op_i.is_rem &
              (upper_nz | (op_i.is_sgn & top_bit & (~neg_quo_i | low_nz)));
    ovf_o   = pre_ovf_i | quo_ovf;

    mag        = op_i.is_rem ? rem_i : quo_i;
    flip       = op_i.is_rem ? neg_rem_i : neg_quo_i;
    signed_val = flip ? (~mag + 1'b1) : mag;

    if (ovf_o) begin
      result_o = '0;
    end else if (op_i.is_w32) begin
      result_o = {{HALF{op_i.is_sgn & signed_val[HALF-1]}}, signed_val[HALF-1:0]};
    end else begin
      result_o = signed_val;
    end

    if (op_i.want_cc) begin
      cc_o = {result_o[W-1], ~result_o[W-1] & (|result_o), ~(|result_o)};
    end else begin
      cc_o = 3'b000;
    end
  end

endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import div_pkg::*;
#(
  parameter int unsigned W     = 64,
  parameter int unsigned TAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      dividend_i,
  input  logic [W-1:0]      divisor_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      result_o,
  output logic              ovf_o,
  output logic [2:0]        cc_o,
  output logic [TAG_W-1:0]  tag_o
);

  localparam int unsigned HALF  = W / 2;
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  logic               rst_sync_n;
  div_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  div_op_t            op_dec, op_q;
  logic [W-1:0]       a_q, b_q;
  logic [TAG_W-1:0]   tag_q;
  logic               accept;
  logic               done_q;
  logic [W-1:0]       result_q;
  logic               ovf_q;
  logic [2:0]         cc_q;

  logic [W-1:0]       hi_mag, lo_mag, dvs_mag, quo, rem, fix_result;
  logic               neg_quo, neg_rem, pre_ovf, fix_ovf;
  logic [2:0]         fix_cc;

  div_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  div_decode u_decode (
    .func_i (func_i),
    .op_o   (op_dec)
  );

  div_shape #(.W(W)) u_shape (
    .op_i      (op_q),
    .a_i       (a_q),
    .b_i       (b_q),
    .hi_mag_o  (hi_mag),
    .lo_mag_o  (lo_mag),
    .dvs_mag_o (dvs_mag),
    .neg_quo_o (neg_quo),
    .neg_rem_o (neg_rem),
    .pre_ovf_o (pre_ovf)
  );

  div_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (state_q == ST_SETUP),
    .step_en (state_q == ST_ITER),
    .hi_i    (hi_mag),
    .lo_i    (lo_mag),
    .dvs_i   (dvs_mag),
    .quo_o   (quo),
    .rem_o   (rem)
  );

  div_fixup #(.W(W)) u_fixup (
    .op_i      (op_q),
    .quo_i     (quo),
    .rem_i     (rem),
    .neg_quo_i (neg_quo),
    .neg_rem_i (neg_rem),
    .pre_ovf_i (pre_ovf),
    .result_o  (fix_result),
    .ovf_o     (fix_ovf),
    .cc_o      (fix_cc)
  );

  assign accept = (state_q == ST_IDLE) & start_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_ITER;
        cnt_d   = '0;
      end
      ST_ITER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) state_d = ST_FIX;
      end
      ST_FIX:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      op_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      tag_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      ovf_q    <= 1'b0;
      cc_q     <= 3'b000;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_q == ST_FIX);
      if (accept) begin
        op_q  <= op_dec;
        a_q   <= dividend_i;
        b_q   <= divisor_i;
        tag_q <= tag_i;
      end
      if (state_q == ST_FIX) begin
        result_q <= fix_result;
        ovf_q    <= fix_ovf;
        cc_q     <= fix_cc;
      end
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;
  assign cc_o     = cc_q;
  assign tag_o    = tag_q;

  AST_FUNC_FORMAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |-> (func_i[9] && func_i[1] && (func_i[5:3] == 3'b010))); // R1

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o) |=> busy_o); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_o); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && start_i) |=> $stable(tag_o)); // R3

  AST_WORD_EXTENDED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && op_q.is_w32) |->
      (result_o[W-1:HALF] == {HALF{op_q.is_sgn & result_o[HALF-1]}})); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && ovf_o) |-> (result_o == '0)); // R9

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> $onehot0(cc_o)); // R10

endmodule

// File: tb/int_div_unit_bench.sv
`timescale 1ns/1ps
module int_div_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] func_i = '0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic [4:0]  tag_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [63:0] result_o;
  logic [2:0]  cc_o;
  logic [4:0]  tag_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit compare_on = 1'b0;

  // reference model state
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_cnt = 0;
  logic [63:0] m_res = '0;
  logic        m_ovf = 1'b0;
  logic [2:0]  m_cc = '0;
  logic [4:0]  m_tag = '0;
  string       m_req = "R4";
  string       next_req = "R4";

  always #2.5 clk = ~clk;

  int_div_unit u_int_div_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .func_i     (func_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .tag_i      (tag_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .ovf_o      (ovf_o),
    .cc_o       (cc_o),
    .tag_o      (tag_o)
  );

  // function field: o,1,d,n,s,010,t,1,r
  function automatic logic [10:0] fn(input logic d, input logic n, input logic s,
                                     input logic o, input logic t, input logic r);
    return {o, 1'b1, d, n, s, 3'b010, t, 1'b1, r};
  endfunction

  // behavioural reference: returns {cc, ovf, result}
  function automatic logic [67:0] ref_div(input logic [10:0] f, input logic [63:0] a,
                                          input logic [63:0] b);
    logic m, s, w, e, rc, sa, sb, neg, ovf;
    logic [63:0] av, bv, am, bm, res;
    logic [127:0] num, den, q, r, lim, val;
    logic [2:0] cc;
    m  = !f[8];
    s  = f[8] ? f[6] : f[10];
    w  = f[2];
    e  = f[8] && !f[7];
    rc = f[0];
    if (w) begin
      av = s ? {{32{a[31]}}, a[31:0]} : {32'b0, a[31:0]};
      bv = s ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]};
    end else begin
      av = a;
      bv = b;
    end
    sa  = s && av[63];
    sb  = s && bv[63];
    neg = sa ^ sb;
    am  = sa ? -av : av;
    bm  = sb ? -bv : bv;
    if (e && w)       num = {64'b0, am} << 32;
    else if (e)       num = {am, 64'b0};
    else              num = {64'b0, am};
    den = {64'b0, bm};
    ovf = 1'b0;
    q = '0;
    r = '0;
    if (bm == 64'd0) ovf = 1'b1;
    else begin
      q = num / den;
      r = num % den;
    end
    if (!m && !ovf) begin
      if (s) begin
        lim = 128'd1 << (w ? 31 : 63);
        if (neg ? (q > lim) : (q >= lim)) ovf = 1'b1;
      end else begin
        lim = 128'd1 << (w ? 32 : 64);
        if (q >= lim) ovf = 1'b1;
      end
    end
    val = m ? (sa ? -r : r) : (neg ? -q : q);
    res = val[63:0];
    if (w) res = s ? {{32{res[31]}}, res[31:0]} : {32'b0, res[31:0]};
    if (ovf) res = '0;
    cc = rc ? {$signed(res) < 0, $signed(res) > 0, res == 64'd0} : 3'b000;
    return {cc, ovf, res};
  endfunction

  // cycle model: accept when idle, done 66 edges later
  always @(posedge clk) begin
    logic [67:0] exp_v;
    if (!rst_n) begin
      m_busy = 1'b0;
      m_done = 1'b0;
      m_cnt  = 0;
    end else begin
      m_done = 1'b0;
      if (!m_busy && start_i) begin
        exp_v  = ref_div(func_i, dividend_i, divisor_i);
        m_res  = exp_v[63:0];
        m_ovf  = exp_v[64];
        m_cc   = exp_v[67:65];
        m_tag  = tag_i;
        m_req  = next_req;
        m_busy = 1'b1;
        m_cnt  = 66;
      end else if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check("R2", "busy", {63'b0, busy_o}, {63'b0, m_busy});
      check("R2", "done", {63'b0, done_o}, {63'b0, m_done});
      if (m_done) begin
        check(m_req, "result", result_o, m_res);
        check((m_req == "R8") ? "R8" : "R9", "ovf", {63'b0, ovf_o}, {63'b0, m_ovf});
        check("R10", "cc", {61'b0, cc_o}, {61'b0, m_cc});
        check("R11", "tag", {59'b0, tag_o}, {59'b0, m_tag});
      end
    end
  end

  task automatic launch(input string req, input logic [10:0] f, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] t);
    @(negedge clk);
    next_req   = req;
    func_i     = f;
    dividend_i = a;
    divisor_i  = b;
    tag_i      = t;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [10:0] f, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] t);
    launch(req, f, a, b, t);
    repeat (68) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12", "busy", {63'b0, busy_o}, 64'd0);
    check("R12", "done", {63'b0, done_o}, 64'd0);
    check("R12", "result", result_o, 64'd0);
    check("R12", "ovf", {63'b0, ovf_o}, 64'd0);
    check("R12", "cc", {61'b0, cc_o}, 64'd0);
    check("R12", "tag", {59'b0, tag_o}, 64'd0);
    compare_on = 1'b1;

    // R4 unsigned doubleword quotient and remainder
    run_op("R4", fn(1,1,0,0,0,0), 64'd100, 64'd7, 5'd1);
    run_op("R4", fn(0,1,0,0,0,0), 64'hFEDC_BA98_7654_3210, 64'h0000_0001_2345_6789, 5'd2);
    run_op("R4", fn(1,1,0,0,0,0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 5'd3);
    // R5 signed quotient and remainder
    run_op("R5", fn(1,1,1,0,0,0), -64'sd100, 64'd7, 5'd4);
    run_op("R5", fn(0,1,0,1,0,0), -64'sd100, 64'd7, 5'd5);
    run_op("R5", fn(1,1,1,0,0,0), 64'd100, -64'sd7, 5'd6);
    // R1 remainder signedness comes from bit 10 only
    run_op("R1", fn(0,1,1,0,0,0), -64'sd100, 64'd7, 5'd7);
    // R1 bit 7 clear on a remainder form does not make it extended
    run_op("R1", fn(0,0,0,0,0,0), 64'd1000, 64'd33, 5'd8);
    // R6 word forms
    run_op("R6", fn(1,1,1,0,1,0), 64'h1234_5678_FFFF_FF9C, 64'hABCD_0000_0000_0007, 5'd9);
    run_op("R6", fn(1,1,0,0,1,0), 64'h0000_0001_FFFF_FFF0, 64'd16, 5'd10);
    run_op("R6", fn(0,1,0,1,1,0), 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007, 5'd11);
    // R7 extended forms
    run_op("R7", fn(1,0,0,0,1,0), 64'd1, 64'd3, 5'd12);
    run_op("R7", fn(1,0,0,0,0,0), 64'd1, 64'd3, 5'd13);
    run_op("R7", fn(1,0,1,0,0,0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 5'd14);
    run_op("R7", fn(1,0,1,0,1,0), 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0004, 5'd15);
    // R8 divide by zero
    run_op("R8", fn(1,1,1,0,0,0), 64'd55, 64'd0, 5'd16);
    run_op("R8", fn(0,1,0,0,0,0), 64'd55, 64'd0, 5'd17);
    run_op("R8", fn(1,1,0,0,1,0), 64'd55, 64'hFFFF_FFFF_0000_0000, 5'd18);
    // R9 overflow limits
    run_op("R9", fn(1,1,1,0,0,0), 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd19);
    run_op("R9", fn(1,1,1,0,1,0), 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 5'd20);
    run_op("R9", fn(1,0,0,0,1,0), 64'd5, 64'd3, 5'd21);
    run_op("R9", fn(1,0,0,0,0,0), 64'd3, 64'd3, 5'd22);
    run_op("R9", fn(1,0,1,0,0,0), 64'd1, 64'd2, 5'd23);
    // R10 condition code
    run_op("R10", fn(1,1,1,0,0,1), -64'sd100, 64'd7, 5'd24);
    run_op("R10", fn(1,1,1,0,0,1), 64'd0, 64'd5, 5'd25);
    run_op("R10", fn(1,1,1,0,0,1), 64'd100, 64'd7, 5'd26);
    run_op("R10", fn(1,1,1,0,0,1), 64'd1, 64'd0, 5'd27);
    // R3 start while busy is ignored
    launch("R3", fn(1,1,0,0,0,0), 64'd999, 64'd10, 5'd28);
    repeat (10) @(negedge clk);
    func_i     = fn(0,1,0,0,0,1);
    dividend_i = 64'd5;
    divisor_i  = 64'd0;
    tag_i      = 5'd29;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
    repeat (60) @(negedge clk);
    // R2 back-to-back: start during the done cycle
    launch("R2", fn(1,1,1,0,0,0), -64'sd77, 64'd5, 5'd30);
    while (!done_o) @(negedge clk);
    next_req   = "R2";
    func_i     = fn(0,1,0,1,0,1);
    dividend_i = -64'sd77;
    divisor_i  = 64'd5;
    tag_i      = 5'd31;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
    repeat (70) @(negedge clk);
    finish_run();
  end

endmodule